// File: doc/BRIEF.md
# Clipped Optical-Black Pixel Averager

This block forms the black-level estimate used by an offset calibration loop. It takes 12-bit converter samples that an external sequencer has marked as optical-black pixels. Each sample is limited to a ceiling of 511 before it joins a running sum. A defective bright pixel therefore cannot drag the black level upward. Once the programmed number of samples has been summed, the block presents their mean together with a one-cycle ready strobe. It then starts the next sum from zero.

The sample count is a power of two chosen by a 3-bit select, from 4 to 512. A sum may span as many lines as the count needs: gaps in the qualify strobe simply pause it. The select is captured only when the sequencer issues a clear, so a count change can never corrupt a sum that is already in progress. Reset loads a default select of 5, which gives 128 samples. The clipping exists only inside this block; the converter's own output bus is not routed through it.

The controller has two states:
- `ST_FILL` sums samples.
- `ST_REPORT` is the single cycle in which the ready strobe is high.

There are three transitions:
- `T_COMPLETE` (FILL to REPORT) happens when the final sample is accepted.
- `T_RESUME` (REPORT to FILL) happens on the following cycle.
- `T_CLEAR` (any state to FILL) happens on a clear and takes priority over the other two.

Top module: `obk_avg_top`

## Requirements
- R1: A qualified sample above 511 contributes exactly 511 to the sum.
- R2: A qualified sample of 511 or less contributes its own value unchanged.
- R3: A captured select code k (0..7) sets the count N = 2^(k+2). The output `avg_o` equals floor(sum of the N clipped samples / N), zero-extended to 12 bits.
- R4: After reset, `avg_o` is 0 and `avg_rdy_o` is 0. The captured code is 5 (N = 128), whatever `cnt_sel_i` holds.
- R5: `avg_rdy_o` is high for exactly one cycle. That cycle is the one right after the clock edge that accepted the N-th sample. `avg_o` carries the new mean in that same cycle.
- R6: Cycles with `samp_vld_i` low are ignored. Accumulation resumes across any number of such cycles and never restarts by itself at a gap.
- R7: The sum restarts from zero after each completed average. A sample accepted during the ready cycle counts as the first sample of the next average.
- R8: `cnt_sel_i` is captured only in a cycle with `clr_i` high. Changes at any other time have no effect on the count.
- R9: `clr_i` discards any partial sum and suppresses the ready strobe in the next cycle, even when a final sample arrives in the same cycle. A sample offered in the clear cycle is not counted.
- R10: `avg_o` holds its value in every cycle in which `avg_rdy_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_i | input | 12 | Converter sample |
| samp_vld_i | input | 1 | Qualifies `samp_i` as an optical-black pixel |
| cnt_sel_i | input | 3 | Count select code, captured on clear |
| clr_i | input | 1 | Sequencer clear: drop partial sum, capture select |
| avg_o | output | 12 | Mean of the last completed group of clipped samples |
| avg_rdy_o | output | 1 | One-cycle strobe marking a fresh `avg_o` |

## Verification
A miscounted sample counter shows up as a ready strobe that comes early, late or twice. A bad limit decode does the same. The bench sees this at the first average after the fault, because it watches the strobe during the whole group. A sum that keeps residue across averages, or that takes a bubble or clear-cycle sample, gives a wrong mean at the very next strobe. A select register that loads outside a clear gives a group of the wrong length. Any of these is visible within one group of at most 512 accepted samples.

// File: rtl/obk_avg_pkg.sv
package obk_avg_pkg;

    // Controller states: summing, and the single reporting cycle.
    typedef enum logic [0:0] {
        ST_FILL   = 1'b0,
        ST_REPORT = 1'b1
    } avg_state_e;

    // Number of bits needed to hold the value v.
    function automatic int bits_for(input int v);
        int n;
        n = 1;
        while ((1 << n) <= v) n++;
        return n;
    endfunction

endpackage

// File: rtl/obk_clip.sv
// Saturates a sample to a fixed ceiling for the calibration path only.
module obk_clip #(
    parameter int SAMP_W   = 12,
    parameter int CLIP_MAX = 511,
    parameter int CLIP_W   = 9
) (
    input  logic [SAMP_W-1:0] samp_i,
    output logic [CLIP_W-1:0] clip_o
);
    localparam logic [SAMP_W-1:0] CEIL = SAMP_W'(CLIP_MAX);

    always_comb begin
        if (samp_i > CEIL) begin
            clip_o = CLIP_W'(CLIP_MAX);
        end else begin
            clip_o = samp_i[CLIP_W-1:0];
        end
    end
endmodule

// File: rtl/obk_sel_reg.sv
// Holds the count select; it loads only on a sequencer clear.
module obk_sel_reg #(
    parameter int SEL_W   = 3,
    parameter int DEF_SEL = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [SEL_W-1:0] code_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o <= SEL_W'(DEF_SEL);
        end else if (clr_i) begin
            code_o <= sel_i;
        end
    end
endmodule

// File: rtl/obk_accum.sv
// Running sum of clipped samples and a count of accepted samples.
module obk_accum #(
    parameter int CLIP_W = 9,
    parameter int ACC_W  = 18,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              take_i,
    input  logic              fin_i,
    input  logic [CLIP_W-1:0] clip_i,
    output logic [ACC_W-1:0]  sum_o,
    output logic [ACC_W-1:0]  total_o,
    output logic [CNT_W-1:0]  cnt_o
);
    // Sum including the sample on offer this cycle.
    always_comb begin
        total_o = sum_o + ACC_W'(clip_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_o <= '0;
            cnt_o <= '0;
        end else if (clr_i) begin
            sum_o <= '0;
            cnt_o <= '0;
        end else if (take_i && fin_i) begin
            // Group complete: start the next one from zero.
            sum_o <= '0;
            cnt_o <= '0;
        end else if (take_i) begin
            sum_o <= total_o;
            cnt_o <= cnt_o + CNT_W'(1);
        end
    end
endmodule

// File: rtl/obk_ctrl.sv
// Sequencing FSM: decides acceptance, group completion and the ready strobe.
module obk_ctrl
    import obk_avg_pkg::*;
#(
    parameter int SEL_W    = 3,
    parameter int MIN_LOG2 = 2,
    parameter int CNT_W    = 10,
    parameter int SH_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_vld_i,
    input  logic             clr_i,
    input  logic [SEL_W-1:0] code_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             take_o,
    output logic             fin_o,
    output logic [SH_W-1:0]  shamt_o,
    output logic             rdy_o
);
    avg_state_e state_q, state_d;
    logic [CNT_W-1:0] last_idx;

    // Shift amount and index of the final sample of a group.
    always_comb begin
        shamt_o  = SH_W'(code_i) + SH_W'(MIN_LOG2);
        last_idx = (CNT_W'(1) << shamt_o) - CNT_W'(1);
        take_o   = samp_vld_i && !clr_i;
        fin_o    = (cnt_i == last_idx);
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: begin
                if (clr_i) begin
                    state_d = ST_FILL;            // T_CLEAR
                end else if (take_o && fin_o) begin
                    state_d = ST_REPORT;          // T_COMPLETE
                end
            end
            ST_REPORT: begin
                if (clr_i) begin
                    state_d = ST_FILL;            // T_CLEAR
                end else if (take_o && fin_o) begin
                    state_d = ST_REPORT;          // T_COMPLETE
                end else begin
                    state_d = ST_FILL;            // T_RESUME
                end
            end
            default: state_d = ST_FILL;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs.
    always_comb begin
        rdy_o = 1'b0;
        unique case (state_q)
            ST_FILL:   rdy_o = 1'b0;
            ST_REPORT: rdy_o = 1'b1;
            default:   rdy_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/obk_avg_top.sv
// Clipped optical-black averager: clip, sum a power-of-two group, report the mean.
module obk_avg_top
    import obk_avg_pkg::*;
#(
    parameter int SAMP_W   = 12,
    parameter int CLIP_MAX = 511,
    parameter int SEL_W    = 3,
    parameter int DEF_SEL  = 5,
    parameter int MIN_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SAMP_W-1:0] samp_i,
    input  logic              samp_vld_i,
    input  logic [SEL_W-1:0]  cnt_sel_i,
    input  logic              clr_i,
    output logic [SAMP_W-1:0] avg_o,
    output logic              avg_rdy_o
);
    localparam int CLIP_W   = bits_for(CLIP_MAX);
    localparam int MAX_LOG2 = MIN_LOG2 + (1 << SEL_W) - 1;
    localparam int CNT_W    = MAX_LOG2 + 1;
    localparam int ACC_W    = CLIP_W + MAX_LOG2;
    localparam int SH_W     = bits_for(MAX_LOG2);

    logic [CLIP_W-1:0] clip_val;
    logic [SEL_W-1:0]  code_q;
    logic [ACC_W-1:0]  acc_sum;
    logic [ACC_W-1:0]  acc_total;
    logic [CNT_W-1:0]  acc_cnt;
    logic [SH_W-1:0]   shamt;
    logic              take;
    logic              fin;
    logic [ACC_W-1:0]  mean_full;

    obk_clip #(
        .SAMP_W  (SAMP_W),
        .CLIP_MAX(CLIP_MAX),
        .CLIP_W  (CLIP_W)
    ) i_clip (
        .samp_i(samp_i),
        .clip_o(clip_val)
    );

    obk_sel_reg #(
        .SEL_W  (SEL_W),
        .DEF_SEL(DEF_SEL)
    ) i_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_i),
        .sel_i (cnt_sel_i),
        .code_o(code_q)
    );

    obk_accum #(
        .CLIP_W(CLIP_W),
        .ACC_W (ACC_W),
        .CNT_W (CNT_W)
    ) i_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr_i),
        .take_i (take),
        .fin_i  (fin),
        .clip_i (clip_val),
        .sum_o  (acc_sum),
        .total_o(acc_total),
        .cnt_o  (acc_cnt)
    );

    obk_ctrl #(
        .SEL_W   (SEL_W),
        .MIN_LOG2(MIN_LOG2),
        .CNT_W   (CNT_W),
        .SH_W    (SH_W)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp_vld_i(samp_vld_i),
        .clr_i     (clr_i),
        .code_i    (code_q),
        .cnt_i     (acc_cnt),
        .take_o    (take),
        .fin_o     (fin),
        .shamt_o   (shamt),
        .rdy_o     (avg_rdy_o)
    );

    // Divide by the group size with a shift.
    always_comb begin
        mean_full = acc_total >> shamt;
    end

    // Result register, loaded when a group completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avg_o <= '0;
        end else if (take && fin) begin
            avg_o <= mean_full[SAMP_W-1:0];
        end
    end
endmodule

// File: rtl/obk_avg_chk.sv
// Checker attached to the averager through bind.
module obk_avg_chk #(
    parameter int SAMP_W   = 12,
    parameter int CLIP_MAX = 511,
    parameter int SEL_W    = 3,
    parameter int ACC_W    = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              samp_vld_i,
    input logic              clr_i,
    input logic [SAMP_W-1:0] avg_o,
    input logic              avg_rdy_o,
    input logic [SEL_W-1:0]  code_q,
    input logic [ACC_W-1:0]  acc_sum
);
    // R1: a mean of clipped samples never exceeds the ceiling.
    a_r1_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        avg_o <= SAMP_W'(CLIP_MAX));

    // R5: the ready strobe lasts one cycle.
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        avg_rdy_o |=> !avg_rdy_o);

    // R5: a strobe follows an accepted sample.
    a_r5_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(avg_rdy_o) |-> ($past(samp_vld_i) && !$past(clr_i)));

    // R6: an idle cycle leaves the running sum untouched.
    a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!samp_vld_i && !clr_i) |=> $stable(acc_sum));

    // R7: the sum restarts from zero when a group completes.
    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(avg_rdy_o) |-> (acc_sum == '0));

    // R8: the captured select moves only on a clear.
    a_r8_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> $stable(code_q));

    // R9: no strobe in the cycle after a clear.
    a_r9_clr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !avg_rdy_o);

    // R10: the result holds while no strobe is shown.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !avg_rdy_o |-> $stable(avg_o));
endmodule

bind obk_avg_top obk_avg_chk #(
    .SAMP_W  (SAMP_W),
    .CLIP_MAX(CLIP_MAX),
    .SEL_W   (SEL_W),
    .ACC_W   (ACC_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .samp_vld_i(samp_vld_i),
    .clr_i     (clr_i),
    .avg_o     (avg_o),
    .avg_rdy_o (avg_rdy_o),
    .code_q    (code_q),
    .acc_sum   (acc_sum)
);

// File: tb/test_obk_avg_top.sv
module test_obk_avg_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    typedef struct packed {
        logic [2:0]  sel;
        logic [11:0] base;
        logic [11:0] step;
        logic [11:0] expv;
    } vec_t;

    // Samples are base + i*step; expv is the expected clipped mean.
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 12'd100,  12'd0, 12'd100},
        '{3'd1, 12'd4095, 12'd0, 12'd511},
        '{3'd2, 12'd500,  12'd1, 12'd506},
        '{3'd3, 12'd0,    12'd0, 12'd0},
        '{3'd0, 12'd10,   12'd3, 12'd14},
        '{3'd1, 12'd508,  12'd1, 12'd510},
        '{3'd4, 12'd300,  12'd0, 12'd300},
        '{3'd7, 12'd4095, 12'd0, 12'd511},
        '{3'd5, 12'd0,    12'd4, 12'd254},
        '{3'd6, 12'd0,    12'd2, 12'd255}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] samp = '0;
    logic        samp_vld = 1'b0;
    logic [2:0]  cnt_sel = '0;
    logic        clr = 1'b0;
    logic [11:0] avg;
    logic        avg_rdy;

    int n_tests = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    obk_avg_top i_obk_avg_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp_i    (samp),
        .samp_vld_i(samp_vld),
        .cnt_sel_i (cnt_sel),
        .clr_i     (clr),
        .avg_o     (avg),
        .avg_rdy_o (avg_rdy)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic drive(input logic v, input logic [11:0] d, input logic c, input logic [2:0] s);
        @(negedge clk);
        samp_vld = v;
        samp = d;
        clr = c;
        cnt_sel = s;
    endtask

    // Feed n samples of value d with no bubbles; count strobes seen early.
    task automatic feed_const(input int n, input logic [11:0] d, input logic [2:0] s, output int early);
        early = 0;
        for (int i = 0; i < n; i++) begin
            drive(1'b1, d, 1'b0, s);
            if (avg_rdy) early++;
        end
    endtask

    // After the final sample was driven: check strobe, value, then single pulse.
    task automatic expect_report(input int expv, input string req);
        drive(1'b0, 12'd4095, 1'b0, cnt_sel);
        check(avg_rdy == 1'b1, {req, " ready"}, avg_rdy, 1);
        check(avg == 12'(expv), {req, " mean"}, avg, expv);
        drive(1'b0, 12'd4095, 1'b0, cnt_sel);
        check(avg_rdy == 1'b0, "R5 single pulse", avg_rdy, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int early;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: reset state
        check(avg == 12'd0, "R4 reset avg", avg, 0);
        check(avg_rdy == 1'b0, "R4 reset ready", avg_rdy, 0);

        // R4/R8: default count 128 with cnt_sel held at 0 and no clear
        feed_const(127, 12'd200, 3'd0, early);
        drive(1'b0, 12'd0, 1'b0, 3'd0);
        check(avg_rdy == 1'b0 && early == 0, "R4 default count not reached at 127", early, 0);
        drive(1'b1, 12'd200, 1'b0, 3'd0);
        expect_report(200, "R4 default 128");

        // Table: R1 R2 R3 R6, bubbles carry 4095 and a wrong select
        for (int v = 0; v < NVEC; v++) begin
            n = 1 << (int'(VECS[v].sel) + 2);
            drive(1'b0, 12'd0, 1'b1, VECS[v].sel);
            early = 0;
            for (int i = 0; i < n; i++) begin
                if (i % 3 == 2) begin
                    drive(1'b0, 12'd4095, 1'b0, ~VECS[v].sel);
                    if (avg_rdy) early++;
                end
                drive(1'b1, 12'(int'(VECS[v].base) + i * int'(VECS[v].step)), 1'b0, VECS[v].sel);
                if (avg_rdy) early++;
            end
            check(early == 0, "R5 no early strobe", early, 0);
            expect_report(int'(VECS[v].expv), "R3 R1 R2 R6 table");
        end

        // R10: value holds with no samples
        repeat (5) drive(1'b0, 12'd0, 1'b0, 3'd0);
        check(avg == 12'd255 && avg_rdy == 1'b0, "R10 hold", avg, 255);

        // R7: back-to-back groups, sample in ready cycle starts next group
        drive(1'b0, 12'd0, 1'b1, 3'd0);
        feed_const(4, 12'd100, 3'd0, early);
        drive(1'b1, 12'd40, 1'b0, 3'd0);
        check(avg_rdy == 1'b1 && avg == 12'd100, "R7 first group", avg, 100);
        feed_const(3, 12'd40, 3'd0, early);
        expect_report(40, "R7 second group restarts");

        // R8: select change without clear is ignored (stays at 4 samples)
        drive(1'b0, 12'd0, 1'b1, 3'd0);
        feed_const(2, 12'd60, 3'd0, early);
        feed_const(2, 12'd60, 3'd3, early);
        expect_report(60, "R8 select held");

        // R9: clear drops a partial sum
        drive(1'b0, 12'd0, 1'b1, 3'd0);
        feed_const(3, 12'd400, 3'd0, early);
        drive(1'b0, 12'd0, 1'b1, 3'd0);
        feed_const(4, 12'd8, 3'd0, early);
        expect_report(8, "R9 partial discarded");

        // R9: clear with final sample suppresses report; clear-cycle sample ignored
        drive(1'b0, 12'd0, 1'b1, 3'd0);
        feed_const(3, 12'd300, 3'd0, early);
        drive(1'b1, 12'd300, 1'b1, 3'd0);
        drive(1'b0, 12'd0, 1'b0, 3'd0);
        check(avg_rdy == 1'b0, "R9 no strobe after clear", avg_rdy, 0);
        feed_const(3, 12'd20, 3'd0, early);
        drive(1'b0, 12'd0, 1'b0, 3'd0);
        check(avg_rdy == 1'b0, "R9 clear-cycle sample not counted", avg_rdy, 0);
        drive(1'b1, 12'd20, 1'b0, 3'd0);
        expect_report(20, "R9 fresh group");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule